// File: doc/BRIEF.md
# Audio-Frame Heartbeat Generator

This block drives a slow square wave that a supervising microcontroller watches to confirm that the audio processor is still running. The time base is the audio sample frame, not the system clock. The incoming left/right word clock is synchronised into the system clock domain. Each rising edge of that clock counts as one frame. After a fixed number of frames, the heartbeat output flips level.

Because the period is a count of frames, the length of each phase scales with the sample rate. With the default count of 8832 frames, a phase lasts 184 ms at 48 kHz, about 200 ms at 44.1 kHz and 276 ms at 32 kHz. If the audio interface stops delivering frames, or the run flag is withdrawn, the output freezes at its present level. A host that sees the heartbeat stop can then decide to reset the processor. That decision is made outside this block.

Top module: `frame_heartbeat`

## Requirements
- R1: While `rst_n` is low, `beat` is 0 and the frame count is cleared, so after any reset a full `FRAMES` frames are needed before the first toggle.
- R2: With `run` high, `beat` inverts exactly once for every `FRAMES` counted frames (default 8832) and at no other time.
- R3: Only a 0-to-1 transition of `lrck` counts as a frame. Holding `lrck` high for any length of time counts once, and falling edges count nothing.
- R4: When the `FRAMES`-th counted rising edge of `lrck` is first sampled at clock edge k, `beat` changes at clock edge k+2 and not before.
- R5: While `run` is low, frames are ignored and the partial count is kept. Once `run` returns high, counting resumes from the held value.
- R6: When `lrck` stops toggling, `beat` holds its level indefinitely.
- R7: A frame edge arriving while the count stands at `FRAMES`-1 returns the count to zero in the same step that toggles `beat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Left/right word clock, asynchronous to `clk` |
| run | input | 1 | When high, frames are counted |
| beat | output | 1 | Heartbeat square wave |

## Verification
The hardest condition to reach from the ports is a count that has been left part-way through a phase, because the count itself is never visible. The bench reaches it in two ways. In one, it withdraws `run` in mid-phase and sends a burst of ignored frames. In the other, it resets after a partial phase. In both cases it then counts the frames needed for the next toggle, so the hidden count shows up as the exact frame on which `beat` flips. The same approach, with one very long high level on `lrck`, confirms that a held level is counted only once.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Next frame count: wraps to zero after the last frame of a phase.
  function automatic int unsigned frame_step(input int unsigned cur,
                                             input int unsigned frames);
    if (cur + 1 >= frames) return 0;
    return cur + 1;
  endfunction

  // True when the current count is the final frame of a phase.
  function automatic bit frame_last(input int unsigned cur,
                                    input int unsigned frames);
    return (cur + 1 >= frames);
  endfunction

  // Counter width for a given frame limit.
  function automatic int unsigned count_width(input int unsigned frames);
    return (frames > 1) ? $clog2(frames) : 1;
  endfunction

endpackage

// File: rtl/lr_edge_sync.sv
module lr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[TOP-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[TOP];
  end

  assign rise = sync_q[TOP] & ~prev_q;
endmodule

// File: rtl/frame_counter.sv
module frame_counter
  import hb_pkg::*;
#(
  parameter int unsigned FRAMES = 8832,
  localparam int unsigned CW    = count_width(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_in,
  input  logic          run,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic          take;
  logic [CW-1:0] cnt_q;

  assign take  = frame_in & run;
  assign wrap  = take & frame_last(int'(cnt_q), FRAMES);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (take) cnt_q <= CW'(frame_step(int'(cnt_q), FRAMES));
  end
endmodule

// File: rtl/phase_toggle.sv
module phase_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= 1'b0;
    else if (flip) level <= ~level;
  end
endmodule

// File: rtl/frame_heartbeat.sv
module frame_heartbeat
  import hb_pkg::*;
#(
  parameter int unsigned FRAMES      = 8832,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = count_width(FRAMES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic run,
  output logic beat
);
  // Named internal events, observed by the bound checker.
  logic          frame_rise;
  logic [CW-1:0] frame_cnt;
  logic          phase_wrap;

  lr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (lrck),
    .rise     (frame_rise)
  );

  frame_counter #(.FRAMES(FRAMES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_in (frame_rise),
    .run      (run),
    .count    (frame_cnt),
    .wrap     (phase_wrap)
  );

  phase_toggle u_tgl (
    .clk   (clk),
    .rst_n (rst_n),
    .flip  (phase_wrap),
    .level (beat)
  );
endmodule

// File: rtl/hb_checker.sv
module hb_checker
  import hb_pkg::*;
#(
  parameter int unsigned FRAMES = 8832,
  localparam int unsigned CW    = count_width(FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          frame_rise,
  input logic [CW-1:0] count,
  input logic          wrap,
  input logic          beat
);
  localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!beat && count == '0));

  assert_flip_needs_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat != $past(beat)) |-> $past(wrap));

  assert_wrap_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (beat != $past(beat)));

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST);

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> !frame_rise);

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rise && run && count != LAST) |=> count == $past(count) + 1'b1);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(count) && $stable(beat)));

  assert_no_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rise |=> ($stable(count) && $stable(beat)));

  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
endmodule

bind frame_heartbeat hb_checker #(.FRAMES(FRAMES)) u_hb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .frame_rise (frame_rise),
  .count      (frame_cnt),
  .wrap       (phase_wrap),
  .beat       (beat)
);

// File: tb/test_frame_heartbeat.sv
`timescale 1ns/1ps
module test_frame_heartbeat;
  localparam int unsigned FR = 16;
  localparam int unsigned HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, lrck = 1'b0, run = 1'b0;
  logic beat;
  int   checks = 0, errors = 0;
  bit   done = 0;

  typedef struct { bit exp; string tag; } item_t;
  item_t exp_q[$];
  event  chk_ev;

  int unsigned m_cnt = 0;
  bit          m_beat = 0;

  always #4 clk = ~clk;

  frame_heartbeat #(.FRAMES(FR)) i_frame_heartbeat (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .run(run), .beat(beat)
  );

  // Monitor: pops expected items and compares with the pin.
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (beat !== it.exp) begin
        errors++;
        $display("FAIL %s: beat=%0b expected=%0b", it.tag, beat, it.exp);
      end
    end
  end

  task automatic expect_beat(input bit e, input string tag);
    exp_q.push_back('{e, tag});
    -> chk_ev;
    #0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one frame, with model update.
  task automatic send_frame(input int hi = HALF);
    @(negedge clk); lrck = 1'b1;
    idle(hi);
    lrck = 1'b0;
    idle(HALF);
    if (run) begin
      m_cnt++;
      if (m_cnt == FR) begin m_cnt = 0; m_beat = ~m_beat; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    m_cnt = 0; m_beat = 0;
    expect_beat(1'b0, "R1 beat low in reset");
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    idle(3);
    expect_beat(1'b0, "R1 beat low in reset");
    rst_n = 1'b1; run = 1'b1;
    idle(3);
    expect_beat(1'b0, "R1 beat low after reset");

    // R2: two full phases, checked after every frame.
    for (int i = 0; i < 2 * FR; i++) begin
      send_frame();
      expect_beat(m_beat, "R2 per-frame level");
    end

    // R4: exact latency of the toggle.
    for (int i = 0; i < FR - 1; i++) send_frame();
    expect_beat(m_beat, "R4 before last frame");
    @(negedge clk); lrck = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_beat(m_beat, "R4 no change after edge k");
    @(posedge clk); @(negedge clk);
    expect_beat(m_beat, "R4 no change after edge k+1");
    @(posedge clk); @(negedge clk);
    expect_beat(~m_beat, "R4 change after edge k+2");
    idle(HALF); lrck = 1'b0; idle(HALF);
    m_cnt = 0; m_beat = ~m_beat;

    // R3: one very long high level counts as a single frame.
    send_frame(400);
    for (int i = 0; i < FR - 2; i++) send_frame();
    expect_beat(m_beat, "R3 long high counted once");
    send_frame();
    expect_beat(m_beat, "R3/R7 toggle on frame FR");
    send_frame();
    expect_beat(m_beat, "R7 count restarted from zero");

    // R5: run low mid-phase holds the partial count.
    for (int i = 0; i < 5; i++) send_frame();
    run = 1'b0;
    for (int i = 0; i < 3 * FR; i++) send_frame();
    expect_beat(m_beat, "R5 frames ignored while run low");
    run = 1'b1;
    for (int i = 0; i < FR - 7; i++) send_frame();
    expect_beat(m_beat, "R5 held count, one frame short");
    send_frame();
    expect_beat(m_beat, "R5 toggle from held count");

    // R6: stall with lrck stuck low, then stuck high.
    for (int i = 0; i < FR - 1; i++) send_frame();
    idle(2000);
    expect_beat(m_beat, "R6 stall low holds");
    @(negedge clk); lrck = 1'b1;
    idle(5);
    m_cnt = 0; m_beat = ~m_beat;
    expect_beat(m_beat, "R6 last edge then stuck high");
    idle(2000);
    expect_beat(m_beat, "R6 stall high holds");
    lrck = 1'b0; idle(HALF);

    // R1: reset mid-phase with beat high clears the partial count.
    for (int i = 0; i < FR; i++) send_frame();
    for (int i = 0; i < 9; i++) send_frame();
    do_reset();
    for (int i = 0; i < FR - 1; i++) send_frame();
    expect_beat(1'b0, "R1 partial count cleared");
    send_frame();
    expect_beat(1'b1, "R1 first toggle after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule